// File: doc/BRIEF.md
# Interrupt Message Write Receiver

This block is a memory-mapped slave that accepts message-signalled interrupts from devices. Its address window is split into 4 KiB pages, one per interrupt file. A device raises an interrupt by writing a 32-bit identity number into the message word at the base of the page that belongs to the target interrupt file. The receiver checks the access and turns each acceptable message into a one-cycle set-pending event that carries the page index and the identity. The interrupt files downstream hold the pending bits and pick priorities. The receiver itself stores no pending state.

Every request gets a response one cycle later. Reads are accepted and return zero. Misaligned accesses, partial-width accesses and accesses beyond the mapped window get an error flag and have no other effect. Writes to the big-endian message word at offset 0x004, or to any other word of a page, are completed without error and without effect. Messages whose identity is zero, or is not below the identity-slot count, are also dropped.

Top module: `irq_msg_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, rsp_valid_o, err_o and set_valid_o are 0 and rdata_o is zero.
- R2: An access whose address has addr_i[1:0] other than 0 gets err_o=1 in its response and produces no set-pending event.
- R3: An access with addr_i at or above NUM_PAGES*4096 gets err_o=1 in its response and produces no set-pending event.
- R4: An error-free write to page offset 0x000 with wdata_i in 1..NUM_IDS-1 raises set_valid_o in the response cycle, with set_page_o = addr_i[12 +: page width] and set_id_o = wdata_i.
- R5: An error-free write to page offset 0x004 (the big-endian message word) completes with err_o=0 and no set-pending event.
- R6: An error-free write to any page offset other than 0x000 and 0x004 completes with err_o=0 and no set-pending event.
- R7: A write to offset 0x000 whose wdata_i is 0 or at least NUM_IDS, including values with upper bits set, completes with err_o=0 and no set-pending event.
- R8: A read completes with rdata_o equal to zero and produces no set-pending event. Its err_o follows R2, R3 and R10.
- R9: Each request cycle is answered by rsp_valid_o high in exactly the next cycle. A cycle without a request is followed by a cycle with rsp_valid_o and set_valid_o low, so each set pulse lasts one cycle per accepted write.
- R10: An access whose byte enables be_i are not all four set (4'hF) gets err_o=1 and produces no set-pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address within the receiver window |
| be_i | input | 4 | Byte enables, must be 4'hF |
| wdata_i | input | 32 | Write data, the interrupt identity |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rdata_o | output | 32 | Read data, always zero |
| err_o | output | 1 | Access rejected, valid with rsp_valid_o |
| set_valid_o | output | 1 | One-cycle set-pending event |
| set_page_o | output | PG_W | Interrupt file (page) of the event |
| set_id_o | output | ID_W | Identity to mark pending |

## Verification
The receiver holds only one cycle of state, so any fault in its decode or its response register shows on the ports in the response cycle of the access that triggers it. It shows as a missing or extra set pulse, a wrong page or identity, or an err_o that does not match the access. The sweep crosses every page, including pages past the window, with the message words, other offsets, misaligned offsets and identities around both validity limits, for reads and writes. This makes each decode fault visible within a single access. An idle cycle after every access shows a set pulse that lasts too long, or a response given without a request.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned BE_W       = DATA_W / 8;
  localparam int unsigned MSG_LE_OFF = 'h000;
  localparam int unsigned MSG_BE_OFF = 'h004;

  typedef enum logic [1:0] {
    WORD_MSG_LE = 2'd0,
    WORD_MSG_BE = 2'd1,
    WORD_OTHER  = 2'd2
  } word_kind_e;

endpackage

// File: rtl/irq_msg_addr_chk.sv
module irq_msg_addr_chk
  import irq_msg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_PAGES  = 8,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              fault_o,
  output logic [PG_W-1:0]   page_o,
  output word_kind_e        kind_o
);

  localparam longint unsigned WIN_LIMIT = longint'(NUM_PAGES) << PAGE_SHIFT;

  logic [63:0]           addr_ext;
  logic [PAGE_SHIFT-1:0] offset;
  logic                  misalign;
  logic                  part_width;
  logic                  beyond;

  assign addr_ext   = 64'(addr_i);
  assign offset     = addr_i[PAGE_SHIFT-1:0];
  assign misalign   = |addr_i[1:0];
  assign part_width = (be_i != {BE_W{1'b1}});
  assign beyond     = (addr_ext >= WIN_LIMIT);
  assign fault_o    = misalign | part_width | beyond;
  assign page_o     = addr_i[PAGE_SHIFT +: PG_W];

  always_comb begin
    if (offset == PAGE_SHIFT'(MSG_LE_OFF))      kind_o = WORD_MSG_LE;
    else if (offset == PAGE_SHIFT'(MSG_BE_OFF)) kind_o = WORD_MSG_BE;
    else                                        kind_o = WORD_OTHER;
  end

endmodule

// File: rtl/irq_msg_id_chk.sv
module irq_msg_id_chk
  import irq_msg_pkg::*;
#(
  parameter int unsigned NUM_IDS = 64,
  localparam int unsigned ID_W   = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic [DATA_W-1:0] wdata_i,
  output logic              id_ok_o,
  output logic [ID_W-1:0]   id_o
);

  // identity 0 is reserved; upper bits must not alias into range
  assign id_ok_o = (wdata_i != '0) && (64'(wdata_i) < 64'(NUM_IDS));
  assign id_o    = wdata_i[ID_W-1:0];

endmodule

// File: rtl/irq_msg_rsp_reg.sv
module irq_msg_rsp_reg #(
  parameter int unsigned PG_W = 3,
  parameter int unsigned ID_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic            fault_i,
  input  logic            msg_word_i,
  input  logic            id_ok_i,
  input  logic [PG_W-1:0] page_i,
  input  logic [ID_W-1:0] id_i,
  output logic            rsp_valid_o,
  output logic            err_o,
  output logic            set_valid_o,
  output logic [PG_W-1:0] set_page_o,
  output logic [ID_W-1:0] set_id_o
);

  logic fire;

  assign fire = req_i & we_i & ~fault_i & msg_word_i & id_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      set_valid_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      err_o       <= req_i & fault_i;
      set_valid_o <= fire;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_page_o <= '0;
      set_id_o   <= '0;
    end else if (fire) begin
      set_page_o <= page_i;
      set_id_o   <= id_i;
    end
  end

endmodule

// File: rtl/irq_msg_rx.sv
module irq_msg_rx
  import irq_msg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_PAGES  = 8,
  parameter int unsigned NUM_IDS    = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int unsigned ID_W      = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic              set_valid_o,
  output logic [PG_W-1:0]   set_page_o,
  output logic [ID_W-1:0]   set_id_o
);

  logic            fault;
  logic [PG_W-1:0] page;
  word_kind_e      kind;
  logic            id_ok;
  logic [ID_W-1:0] id;

  irq_msg_addr_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_PAGES (NUM_PAGES),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_addr_chk (
    .addr_i (addr_i),
    .be_i   (be_i),
    .fault_o(fault),
    .page_o (page),
    .kind_o (kind)
  );

  irq_msg_id_chk #(
    .NUM_IDS(NUM_IDS)
  ) u_id_chk (
    .wdata_i(wdata_i),
    .id_ok_o(id_ok),
    .id_o   (id)
  );

  irq_msg_rsp_reg #(
    .PG_W(PG_W),
    .ID_W(ID_W)
  ) u_rsp_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .fault_i    (fault),
    .msg_word_i (kind == WORD_MSG_LE),
    .id_ok_i    (id_ok),
    .page_i     (page),
    .id_i       (id),
    .rsp_valid_o(rsp_valid_o),
    .err_o      (err_o),
    .set_valid_o(set_valid_o),
    .set_page_o (set_page_o),
    .set_id_o   (set_id_o)
  );

  // message words are write-only
  assign rdata_o = '0;

endmodule

// File: rtl/irq_msg_rx_chk.sv
module irq_msg_rx_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_PAGES  = 8,
  parameter int unsigned NUM_IDS    = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int unsigned ID_W      = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [3:0]        be_i,
  input logic [31:0]       wdata_i,
  input logic              rsp_valid_o,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic              set_valid_o,
  input logic [PG_W-1:0]   set_page_o,
  input logic [ID_W-1:0]   set_id_o
);

  localparam longint unsigned WIN_LIMIT = longint'(NUM_PAGES) << PAGE_SHIFT;

  p_misalign_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |=> (err_o && !set_valid_o));

  p_beyond_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && 64'(addr_i) >= WIN_LIMIT) |=> (err_o && !set_valid_o));

  p_set_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_valid_o |-> (rsp_valid_o && !err_o && 32'(set_page_o) < NUM_PAGES));

  p_only_le_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[PAGE_SHIFT-1:0] != '0) |=> !set_valid_o);

  p_id_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_valid_o |-> (set_id_o != '0 && 32'(set_id_o) < NUM_IDS));

  p_zero_id_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wdata_i == '0) |=> !set_valid_o);

  p_read_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> (!set_valid_o && rdata_o == '0));

  p_rsp_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rsp_valid_o && !set_valid_o));

  p_part_width_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && be_i != 4'hF) |=> (err_o && !set_valid_o));

endmodule

bind irq_msg_rx irq_msg_rx_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_PAGES (NUM_PAGES),
  .NUM_IDS   (NUM_IDS),
  .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (.*);

// File: tb/tb_irq_msg_rx.sv
module tb_irq_msg_rx;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned NP     = 3;
  localparam int unsigned NID    = 12;
  localparam int unsigned PG_W   = 2;
  localparam int unsigned ID_W   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0]        be = 4'hF;
  logic [31:0]       wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rdata;
  logic              err;
  logic              set_valid;
  logic [PG_W-1:0]   set_page;
  logic [ID_W-1:0]   set_id;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_msg_rx #(
    .ADDR_W    (ADDR_W),
    .NUM_PAGES (NP),
    .NUM_IDS   (NID),
    .PAGE_SHIFT(12)
  ) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .we_i       (we),
    .addr_i     (addr),
    .be_i       (be),
    .wdata_i    (wdata),
    .rsp_valid_o(rsp_valid),
    .rdata_o    (rdata),
    .err_o      (err),
    .set_valid_o(set_valid),
    .set_page_o (set_page),
    .set_id_o   (set_id)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // starts and ends at a negedge; samples the response one cycle later
  task automatic access(input logic w, input logic [ADDR_W-1:0] a,
                        input logic [3:0] b, input logic [31:0] d);
    logic  flt;
    logic  fire;
    string tag;
    flt  = (a[1:0] != 2'b00) || (b != 4'hF) || (32'(a) >= NP * 4096);
    fire = w && !flt && (a[11:0] == 12'h000) && (d != 0) && (d < NID);
    if (a[1:0] != 2'b00)          tag = "R2";
    else if (b != 4'hF)           tag = "R10";
    else if (32'(a) >= NP * 4096) tag = "R3";
    else if (!w)                  tag = "R8";
    else if (a[11:0] == 12'h004)  tag = "R5";
    else if (a[11:0] != 12'h000)  tag = "R6";
    else if (!fire)               tag = "R7";
    else                          tag = "R4";
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
    chk("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(tag, "err", 32'(err), 32'(flt));
    chk(tag, "set_valid", 32'(set_valid), 32'(fire));
    chk("R8", "rdata", rdata, 32'd0);
    if (fire) begin
      chk("R4", "set_page", 32'(set_page), 32'(a >> 12));
      chk("R4", "set_id", 32'(set_id), d);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R9", "idle rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R9", "idle set_valid", 32'(set_valid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int offs[8] = '{'h000, 'h004, 'h008, 'h001, 'h002, 'h003, 'hFFC, 'h800};
    logic [3:0] bes[4] = '{4'h1, 4'h3, 4'hE, 4'h0};
    repeat (3) @(negedge clk);
    chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R1", "err in reset", 32'(err), 32'd0);
    chk("R1", "set_valid in reset", 32'(set_valid), 32'd0);
    chk("R1", "rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "set_valid after reset", 32'(set_valid), 32'd0);

    // pages 0..4 cover the window and two pages past it (R3)
    for (int pg = 0; pg < 5; pg++)
      for (int o = 0; o < 8; o++)
        for (int d = 0; d < 15; d++)
          for (int w = 0; w < 2; w++)
            access(w[0], ADDR_W'(pg * 4096 + offs[o]), 4'hF, 32'(d));

    // identities with upper bits set must not alias (R7)
    for (int pg = 0; pg < 3; pg++) begin
      access(1'b1, ADDR_W'(pg * 4096), 4'hF, 32'h0001_0003);
      access(1'b1, ADDR_W'(pg * 4096), 4'hF, 32'h8000_0000);
      access(1'b1, ADDR_W'(pg * 4096), 4'hF, 32'hFFFF_FFFF);
    end

    // partial byte enables on the message word (R10)
    for (int pg = 0; pg < 3; pg++)
      for (int k = 0; k < 4; k++) begin
        access(1'b1, ADDR_W'(pg * 4096), bes[k], 32'd5);
        access(1'b0, ADDR_W'(pg * 4096), bes[k], 32'd0);
      end

    // top of the address space (R3)
    access(1'b1, 16'hF000, 4'hF, 32'd3);
    access(1'b1, 16'hFFFC, 4'hF, 32'd3);
    access(1'b0, 16'h3000, 4'hF, 32'd0);

    // back-to-back messages: two pulses, one per write (R9, R4)
    req = 1'b1; we = 1'b1; be = 4'hF; addr = 16'h1000; wdata = 32'd7;
    @(posedge clk);
    @(negedge clk);
    addr = 16'h2000; wdata = 32'd11;
    chk("R4", "b2b first set_valid", 32'(set_valid), 32'd1);
    chk("R4", "b2b first page", 32'(set_page), 32'd1);
    chk("R4", "b2b first id", 32'(set_id), 32'd7);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R9", "b2b second rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R4", "b2b second page", 32'(set_page), 32'd2);
    chk("R4", "b2b second id", 32'(set_id), 32'd11);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "b2b end set_valid", 32'(set_valid), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule